// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Timing and Level Flags

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Its timing mode is captured from the `mode_sel` input while reset is held and stays fixed until the next reset.

In standard mode, every word, including the first, leaves the buffer only when the reader asks for it. In fall-through mode, the word at the head of the queue is moved into the output register without being asked for. The reader sees that word together with a valid indication, and a read request retires it. Because that output register holds one word, the fall-through mode stores one word more than the memory depth.

Besides the two ready indications, the block drives three active-low level flags: almost-empty, half-full and almost-full. The almost-empty offset and the almost-full offset come from a neighbouring offset-register block as plain inputs.

Top module: `fifo_dualmode`

## Requirements
- R1: The mode is taken from `mode_sel` (0 = standard, 1 = fall-through) only while `rst` is high. Changing `mode_sel` after reset has no effect on behaviour.
- R2: Words leave the buffer in the order they were accepted, in both modes.
- R3: In standard mode, `rd_status` is 0 while no word is stored and 1 once a word is readable. `rd_data` changes only on a read, which is an `rd_en` high on an `rclk` edge.
- R4: In standard mode, `wr_status` is 1 while space remains and 0 after D accepted writes with no reads. A write while full is dropped.
- R5: In fall-through mode, the first word written into an empty buffer appears on `rd_data` with `rd_status` = 0 without any `rd_en`. The word is held there until `rd_en` retires it.
- R6: In fall-through mode, `wr_status` is 0 while space remains and 1 after D+1 accepted writes with no reads. A write while full is dropped.
- R7: `alm_empty_n` is 0 while the stored count is at most n (standard) or n+1 (fall-through), and 1 above that. Here n is `empty_off`.
- R8: `half_n` is 0 when the count is at least D/2+1 (standard) or D/2+2 (fall-through), and 1 below that.
- R9: `alm_full_n` is 0 when the count is at least D-m (standard) or D+1-m (fall-through), including at full. Here m is `full_off`.
- R10: `rd_en` while the buffer is empty has no effect. `rd_data` is unchanged, and the next word written is the next word read.
- R11: One read from a full buffer clears the full indication on `wr_status`.
- R12: After reset, the outputs take their empty-state values:
  - `rd_status` is 0 in standard mode and 1 in fall-through mode.
  - `wr_status` is 1 in standard mode and 0 in fall-through mode.
  - `half_n` = 1, `alm_empty_n` = 0, `alm_full_n` = 1.
  - `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high synchronous reset; must be held over several edges of both clocks |
| mode_sel | input | 1 | Mode choice captured during reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write request, sampled on `wclk` |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read request, sampled on `rclk` |
| rd_data | output | DW | Output word register |
| empty_off | input | AW+1 | Almost-empty offset n |
| full_off | input | AW+1 | Almost-full offset m |
| rd_status | output | 1 | Standard: 1 = data present. Fall-through: 0 = `rd_data` valid |
| wr_status | output | 1 | Standard: 0 = full. Fall-through: 1 = full |
| half_n | output | 1 | Low at or above the half-full level |
| alm_empty_n | output | 1 | Low at or below the almost-empty level |
| alm_full_n | output | 1 | Low at or above the almost-full level |

## Verification
The bench runs each mode from reset and steps the count one word at a time up to capacity, checking all five flags at every level. This sweep exposes off-by-one thresholds, and in particular a fall-through build that forgets the extra word held in the output register would switch every flag one word early. It then attempts a write into a full buffer, which a design with a loose full check would accept and so corrupt the data order. It also reads from an empty buffer, where a design that does not gate the read would move its pointer and skip or repeat a word. Finally, it flips `mode_sel` after reset; a design that follows the pin instead of the captured mode would stop presenting the first word on its own.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, doubles as the output word register
  always_ff @(posedge rclk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/fifo_dualmode.sv
module fifo_dualmode
  import fifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [AW:0]   empty_off,
  input  logic [AW:0]   full_off,
  output logic          rd_status,
  output logic          wr_status,
  output logic          half_n,
  output logic          alm_empty_n,
  output logic          alm_full_n
);
  localparam int PW    = AW + 1;
  localparam int CW    = PW + 1;
  localparam int DEPTH = 1 << AW;

  // ---------------- write domain ----------------
  fifo_mode_e      wmode;
  logic [PW-1:0]   wbin, wgray, wbin_inc;
  logic [PW-1:0]   rbin_s, cbin_s;
  logic [PW-1:0]   mem_cnt_w, tot_cnt_w, cap_w;
  logic [CW-1:0]   tot_x;
  logic            full_w, wr_go, fw_w;

  assign fw_w      = (wmode == MODE_FWFT);
  assign wbin_inc  = wbin + 1'b1;
  assign mem_cnt_w = wbin - rbin_s;
  assign tot_cnt_w = wbin - cbin_s;
  assign cap_w     = fw_w ? PW'(DEPTH + 1) : PW'(DEPTH);
  assign full_w    = (mem_cnt_w == PW'(DEPTH)) || (tot_cnt_w == cap_w);
  assign wr_go     = wr_en && !full_w;
  assign tot_x     = {1'b0, tot_cnt_w};

  always_ff @(posedge wclk) begin
    if (rst) begin
      wmode      <= fifo_mode_e'(mode_sel);
      wbin       <= '0;
      wgray      <= '0;
      half_n     <= 1'b1;
      alm_full_n <= 1'b1;
    end else begin
      if (wr_go) begin
        wbin  <= wbin_inc;
        wgray <= wbin_inc ^ (wbin_inc >> 1);
      end
      half_n     <= !(tot_x >= CW'(DEPTH / 2 + 1) + CW'(fw_w));
      alm_full_n <= !(tot_x + {1'b0, full_off} >= CW'(DEPTH) + CW'(fw_w));
    end
  end

  // full indication kept combinational so it agrees with the write gate
  assign wr_status = fw_w ? full_w : !full_w;

  // ---------------- read domain ----------------
  fifo_mode_e      rmode;
  logic [PW-1:0]   rbin, rgray, rbin_inc;
  logic [PW-1:0]   cbin, cgray, cbin_inc;
  logic [PW-1:0]   wbin_s, rd_cnt;
  logic [CW-1:0]   pae_thr;
  logic            q_vld, mem_empty, fetch, consume, fw_r;

  assign fw_r      = (rmode == MODE_FWFT);
  assign rbin_inc  = rbin + 1'b1;
  assign cbin_inc  = cbin + 1'b1;
  assign mem_empty = (wbin_s == rbin);
  assign fetch     = !mem_empty && (fw_r ? (!q_vld || rd_en) : rd_en);
  assign consume   = fw_r ? (rd_en && q_vld) : fetch;
  assign rd_cnt    = wbin_s - cbin;
  assign pae_thr   = {1'b0, empty_off} + CW'(1) + CW'(fw_r);

  always_ff @(posedge rclk) begin
    if (rst) begin
      rmode       <= fifo_mode_e'(mode_sel);
      rbin        <= '0;
      rgray       <= '0;
      cbin        <= '0;
      cgray       <= '0;
      q_vld       <= 1'b0;
      alm_empty_n <= 1'b0;
    end else begin
      if (fetch) begin
        rbin  <= rbin_inc;
        rgray <= rbin_inc ^ (rbin_inc >> 1);
      end
      if (consume) begin
        cbin  <= cbin_inc;
        cgray <= cbin_inc ^ (cbin_inc >> 1);
      end
      if (fw_r) begin
        if (fetch)      q_vld <= 1'b1;
        else if (rd_en) q_vld <= 1'b0;
      end
      alm_empty_n <= ({1'b0, rd_cnt} >= pae_thr);
    end
  end

  assign rd_status = fw_r ? !q_vld : !mem_empty;

  // ---------------- shared pieces ----------------
  dp_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (wr_go),
    .waddr (wbin[AW-1:0]),
    .wdata (wr_data),
    .rclk  (rclk),
    .rst   (rst),
    .re    (fetch),
    .raddr (rbin[AW-1:0]),
    .rdata (rd_data)
  );

  gray_sync #(.W(PW)) u_wptr_to_r (
    .clk (rclk), .rst (rst), .gray_in (wgray), .bin_out (wbin_s)
  );

  gray_sync #(.W(PW)) u_rptr_to_w (
    .clk (wclk), .rst (rst), .gray_in (rgray), .bin_out (rbin_s)
  );

  gray_sync #(.W(PW)) u_cptr_to_w (
    .clk (wclk), .rst (rst), .gray_in (cgray), .bin_out (cbin_s)
  );
endmodule

// File: rtl/fifo_dualmode_chk.sv
module fifo_dualmode_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wmode_b,
  input logic          fw_r,
  input logic          wr_en,
  input logic          full_w,
  input logic [AW:0]   wbin,
  input logic [AW:0]   mem_cnt_w,
  input logic          rd_en,
  input logic          q_vld,
  input logic          mem_empty,
  input logic [AW:0]   rbin,
  input logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  // R1: captured write-side mode never moves outside reset
  p_mode_fixed_r1: assert property (@(posedge wclk) disable iff (rst)
    $stable(wmode_b));

  // R4 / R6: a refused write leaves the write pointer alone
  p_no_overflow_r4: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && full_w) |=> $stable(wbin));

  // R6: memory occupancy seen from the write side never exceeds the depth
  p_mem_bound_r6: assert property (@(posedge wclk) disable iff (rst)
    mem_cnt_w <= (AW+1)'(DEPTH));

  // R10: a standard-mode read on empty moves nothing
  p_empty_read_r10: assert property (@(posedge rclk) disable iff (rst)
    (!fw_r && mem_empty && rd_en) |=> ($stable(rbin) && $stable(rd_data)));

  // R5: a presented fall-through word stays until it is retired
  p_hold_word_r5: assert property (@(posedge rclk) disable iff (rst)
    (fw_r && q_vld && !rd_en) |=> (q_vld && $stable(rd_data)));
endmodule

bind fifo_dualmode fifo_dualmode_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk      (wclk),
  .rclk      (rclk),
  .rst       (rst),
  .wmode_b   (fw_w),
  .fw_r      (fw_r),
  .wr_en     (wr_en),
  .full_w    (full_w),
  .wbin      (wbin),
  .mem_cnt_w (mem_cnt_w),
  .rd_en     (rd_en),
  .q_vld     (q_vld),
  .mem_empty (mem_empty),
  .rbin      (rbin),
  .rd_data   (rd_data)
);

// File: tb/tb_fifo_dualmode.sv
module tb_fifo_dualmode;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DW   = 8;
  localparam int AW   = 4;
  localparam int D    = 1 << AW;
  localparam int NOFF = 3;
  localparam int MOFF = 2;

  logic          wclk = 1'b0, rclk = 1'b0, rst = 1'b1, mode_sel = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW:0]   empty_off = (AW+1)'(NOFF);
  logic [AW:0]   full_off  = (AW+1)'(MOFF);
  logic          rd_status, wr_status, half_n, alm_empty_n, alm_full_n;

  fifo_dualmode #(.DW(DW), .AW(AW)) dut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .mode_sel(mode_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .empty_off(empty_off), .full_off(full_off),
    .rd_status(rd_status), .wr_status(wr_status), .half_n(half_n),
    .alm_empty_n(alm_empty_n), .alm_full_n(alm_full_n)
  );

  always #(CLK_PERIOD/2)  wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  int            n_chk = 0, n_bad = 0, cnt = 0;
  bit            fw = 1'b0, done = 1'b0;
  logic [DW-1:0] sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_reset(input bit m);
    mode_sel = m;
    rst = 1'b1;
    repeat (6) @(negedge rclk);
    rst = 1'b0;
    fw = m;
    cnt = 0;
    sb.delete();
    repeat (4) @(negedge rclk);
  endtask

  // expected flags from the count and mode (R3..R9)
  task automatic check_flags();
    int  cap = D + int'(fw);
    bit  full = (cnt >= cap);
    bit  e_rs = fw ? (cnt == 0) : (cnt != 0);
    bit  e_ws = fw ? full : !full;
    bit  e_hf = !(cnt >= D/2 + 1 + int'(fw));
    bit  e_pe = (cnt >= NOFF + 1 + int'(fw));
    bit  e_pf = !(cnt + MOFF >= D + int'(fw));
    chk(rd_status == e_rs, fw ? "R5 ready flag" : "R3 data-present flag", rd_status, e_rs);
    chk(wr_status == e_ws, fw ? "R6 full flag" : "R4 full flag", wr_status, e_ws);
    chk(half_n == e_hf, "R8 half-full", half_n, e_hf);
    chk(alm_empty_n == e_pe, "R7 almost-empty", alm_empty_n, e_pe);
    chk(alm_full_n == e_pf, "R9 almost-full", alm_full_n, e_pf);
  endtask

  // driver: pushes the word to the scoreboard when the requirements say it is accepted
  task automatic wr_word(input logic [DW-1:0] v);
    @(negedge wclk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge wclk);
    wr_en = 1'b0;
    if (cnt < D + int'(fw)) begin
      sb.push_back(v);
      cnt++;
    end
  endtask

  // monitor side: retires one word and compares it with the scoreboard head (R2)
  task automatic rd_word();
    logic [DW-1:0] e;
    e = sb.pop_front();
    if (fw) begin
      for (int k = 0; k < 10 && rd_status != 1'b0; k++) @(negedge rclk);
      chk(rd_data == e, "R2 order (fall-through)", rd_data, e);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
    end else begin
      @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      chk(rd_data == e, "R2 order (standard)", rd_data, e);
    end
    cnt--;
  endtask

  task automatic run_mode(input bit m);
    logic [DW-1:0] base = m ? 8'hC0 : 8'h40;
    do_reset(m);
    // R12 reset state
    chk(rd_status == m, "R12 rd_status", rd_status, m);
    chk(wr_status == !m, "R12 wr_status", wr_status, !m);
    chk(half_n == 1'b1, "R12 half_n", half_n, 1);
    chk(alm_empty_n == 1'b0, "R12 alm_empty_n", alm_empty_n, 0);
    chk(alm_full_n == 1'b1, "R12 alm_full_n", alm_full_n, 1);
    chk(rd_data == '0, "R12 rd_data", rd_data, 0);
    // R1: pin flipped after reset must not change the mode
    mode_sel = !m;
    // R10: read while empty does nothing
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    settle();
    chk(rd_data == '0, "R10 data after empty read", rd_data, 0);
    chk(rd_status == m, "R10 still empty", rd_status, m);
    // first word
    wr_word(base);
    settle();
    if (m) begin
      chk(rd_data == base, "R5 first word falls through", rd_data, base);
      chk(rd_status == 1'b0, "R1 fall-through kept despite pin", rd_status, 0);
    end else begin
      chk(rd_data == '0, "R3 no data before a read", rd_data, 0);
      chk(rd_status == 1'b1, "R1 standard kept despite pin", rd_status, 1);
    end
    check_flags();
    // fill to capacity, one level at a time
    while (cnt < D + int'(fw)) begin
      wr_word(base + DW'(cnt));
      settle();
      check_flags();
    end
    // write into a full buffer is dropped (R4 / R6)
    wr_word(8'hEE);
    settle();
    chk(cnt == D + int'(fw), m ? "R6 overflow dropped" : "R4 overflow dropped", cnt, D + int'(fw));
    check_flags();
    // R11: one read clears full
    rd_word();
    settle();
    chk(wr_status == m ? 1'b0 : 1'b1, "R11 full cleared by read", wr_status, m ? 0 : 1);
    check_flags();
    // drain and compare order
    while (cnt > 0) rd_word();
    settle();
    check_flags();
    // R10: empty read then a new word is the next one out
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    settle();
    wr_word(8'hA5);
    settle();
    rd_word();
    settle();
    check_flags();
  endtask

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule